// File: doc/BRIEF.md
# Data-Polling Completion Checker

This block runs on the host side of a flash device and decides whether a program or erase operation has succeeded. It is started once the operation's command sequence has been written. It then reads the device's status word over a synchronous read port, again and again, at one valid address. For a program operation that address is the programmed location. For a sector erase it is any address inside the sector being erased. For a chip erase it is any address in a sector that is not protected.

On each poll the checker compares the status polarity bit with the value the caller expects. The caller supplies the programmed datum's bit for a program and 1 for an erase. If the bits differ, the checker looks at the time-limit flag. A clear flag means the checker polls again. A set flag means the checker reads the status word once more and makes the final comparison, because the two bits can change on the same read. The first read that shows true data may still carry invalid bits in the rest of the word. For that reason a successful check ends with one more read, and that word is presented as the verified data. A poll budget ends a run that never settles.

Top module: `poll_done_checker`

## Requirements
- R1: A start pulse while idle sets busy and issues the first read request in the next cycle. The read address is the start address, and it holds for the whole run. A start pulse while busy has no effect.
- R2: A poll whose status bit 7 equals the expected bit is followed by exactly one more read. When that read returns, pass is set and its full word appears on data_o.
- R3: A poll whose bit 7 differs from the expected bit, with bit 5 clear, is followed by another poll at the same address.
- R4: A poll whose bit 7 differs from the expected bit, with bit 5 set, is followed by one recheck read. If bit 7 matches on the recheck, the run continues as in R2. The bit-5 check takes priority over the poll budget.
- R5: If bit 7 still differs on the recheck read, the run ends with fail, whatever the value of bit 5.
- R6: When MAX_POLLS polls in a row have bit 7 differing and bit 5 clear, the run ends with fail and no further read is issued.
- R7: done_o is high for exactly one cycle, in the same cycle that pass_o or fail_o becomes set. pass_o and fail_o are never high together. Both hold until the next accepted start, which clears them and data_o.
- R8: A read request lasts one cycle. No further request is issued until a read-valid has returned. A read-valid that arrives while no read is outstanding is ignored.
- R9: After reset, rd_req_o, busy_o, done_o, pass_o and fail_o are all 0, and data_o and rd_addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| addr_i | input | ADDR_W | Valid polling address |
| expect_i | input | 1 | Expected value of status bit 7 (1 for an erase) |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation verified |
| fail_o | output | 1 | Operation failed |
| data_o | output | DATA_W | Word from the extra read after a pass |

## Verification
The bench builds the checker with MAX_POLLS set to 4, ADDR_W set to 12 and DATA_W set to 16. The small poll budget makes it cheap to reach the limit-failure path. It also makes it cheap to place a set bit 5 on the very last allowed poll, where the recheck must take priority over the budget. Read latency is varied from one to three cycles, and spurious valid strobes are sent while the block is idle. These cover the one-outstanding-read rule and the holding of the verdict.

// File: rtl/poll_done_pkg.sv
package poll_done_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_FINAL = 2'd3
  } pd_state_t;

  typedef enum logic [1:0] {
    V_MATCH = 2'd0,
    V_TLE   = 2'd1,
    V_AGAIN = 2'd2,
    V_LIMIT = 2'd3
  } pd_verdict_t;

endpackage

// File: rtl/poll_done_eval.sv
module poll_done_eval
  import poll_done_pkg::*;
(
  input  logic        polar_bit,
  input  logic        tle_bit,
  input  logic        expect_bit,
  input  logic        budget_last,
  output pd_verdict_t verdict
);

  always_comb begin
    if (polar_bit == expect_bit)      verdict = V_MATCH;
    else if (tle_bit)                 verdict = V_TLE;
    else if (budget_last)             verdict = V_LIMIT;
    else                              verdict = V_AGAIN;
  end

endmodule

// File: rtl/poll_done_budget.sv
module poll_done_budget #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [CW-1:0] used_q;

  always_ff @(posedge clk) begin
    if (rst || clr)   used_q <= '0;
    else if (inc)     used_q <= used_q + 1'b1;
  end

  assign last = (used_q == CW'(MAX_POLLS - 1));

endmodule

// File: rtl/poll_done_seq.sv
module poll_done_seq
  import poll_done_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              expect_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  pd_verdict_t       verdict_i,
  output logic              expect_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] data_o
);

  pd_state_t state_q;
  logic      exp_q;

  assign expect_o  = exp_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign cnt_clr_o = (state_q == ST_IDLE) && start_i;
  assign cnt_inc_o = (state_q == ST_POLL) && rd_valid_i && (verdict_i == V_AGAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      exp_q     <= 1'b0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      fail_o    <= 1'b0;
      data_o    <= '0;
    end else begin
      rd_req_o <= 1'b0;
      done_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_POLL;
            exp_q     <= expect_i;
            rd_addr_o <= addr_i;
            rd_req_o  <= 1'b1;
            pass_o    <= 1'b0;
            fail_o    <= 1'b0;
            data_o    <= '0;
          end
        end
        ST_POLL: begin
          if (rd_valid_i) begin
            case (verdict_i)
              V_MATCH: begin
                state_q  <= ST_FINAL;
                rd_req_o <= 1'b1;
              end
              V_TLE: begin
                state_q  <= ST_RECHK;
                rd_req_o <= 1'b1;
              end
              V_AGAIN: rd_req_o <= 1'b1;
              default: begin
                state_q <= ST_IDLE;
                fail_o  <= 1'b1;
                done_o  <= 1'b1;
              end
            endcase
          end
        end
        ST_RECHK: begin
          if (rd_valid_i) begin
            if (verdict_i == V_MATCH) begin
              state_q  <= ST_FINAL;
              rd_req_o <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
              fail_o  <= 1'b1;
              done_o  <= 1'b1;
            end
          end
        end
        default: begin
          if (rd_valid_i) begin
            state_q <= ST_IDLE;
            data_o  <= rd_data_i;
            pass_o  <= 1'b1;
            done_o  <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/poll_done_checker.sv
module poll_done_checker
  import poll_done_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 1024,
  parameter int POLAR_POS = 7,
  parameter int TLE_POS   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              expect_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] data_o
);

  pd_verdict_t verdict;
  logic        exp_q;
  logic        cnt_clr;
  logic        cnt_inc;
  logic        budget_last;

  poll_done_eval u_eval (
    .polar_bit   (rd_data_i[POLAR_POS]),
    .tle_bit     (rd_data_i[TLE_POS]),
    .expect_bit  (exp_q),
    .budget_last (budget_last),
    .verdict     (verdict)
  );

  poll_done_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .last (budget_last)
  );

  poll_done_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .expect_i   (expect_i),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .verdict_i  (verdict),
    .expect_o   (exp_q),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .data_o     (data_o)
  );

endmodule

// File: rtl/poll_done_checker_sva.sv
module poll_done_checker_sva #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> (!busy_o || $stable(rd_addr_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pass_o ^ fail_o));

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_o && !start_i) |=> pass_o);

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !start_i) |=> fail_o);

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> !rd_req_o);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rd_req_o && !busy_o && !done_o && !pass_o && !fail_o));

endmodule

bind poll_done_checker poll_done_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/sim_poll_done_checker.sv
`timescale 1ns/100ps
module sim_poll_done_checker;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MAXP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          expect_i = 1'b0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, pass_o, fail_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  poll_done_checker #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .expect_i(expect_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
    .fail_o(fail_o), .data_o(data_o)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge
  int            m_phase = 0;
  int            m_used = 0;
  logic          m_exp = 1'b0;
  logic          m_req = 1'b0, m_done = 1'b0, m_pass = 1'b0, m_fail = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_used = 0; m_req = 0; m_done = 0; m_pass = 0; m_fail = 0;
      m_addr = '0; m_data = '0; m_exp = 0;
    end else begin
      m_req = 0;
      m_done = 0;
      if (m_phase == 0) begin
        if (start_i) begin
          m_phase = 1; m_req = 1; m_addr = addr_i; m_exp = expect_i;
          m_pass = 0; m_fail = 0; m_data = '0; m_used = 0;
        end
      end else if (rd_valid_i) begin
        if (m_phase == 1) begin
          m_used++;
          if (rd_data_i[7] == m_exp) begin m_phase = 3; m_req = 1; end
          else if (rd_data_i[5]) begin m_phase = 2; m_req = 1; end
          else if (m_used >= MAXP) begin m_phase = 0; m_fail = 1; m_done = 1; end
          else m_req = 1;
        end else if (m_phase == 2) begin
          if (rd_data_i[7] == m_exp) begin m_phase = 3; m_req = 1; end
          else begin m_phase = 0; m_fail = 1; m_done = 1; end
        end else begin
          m_phase = 0; m_pass = 1; m_done = 1; m_data = rd_data_i;
        end
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8", "rd_req", 32'(rd_req_o), 32'(m_req));
      chk("R1", "busy", 32'(busy_o), 32'(m_phase != 0));
      if (m_phase != 0) chk("R1", "rd_addr", 32'(rd_addr_o), 32'(m_addr));
      chk("R7", "done", 32'(done_o), 32'(m_done));
      chk("R2", "pass", 32'(pass_o), 32'(m_pass));
      chk("R5", "fail", 32'(fail_o), 32'(m_fail));
      chk("R2", "data", 32'(data_o), 32'(m_data));
    end
  end

  // Read responder with programmable latency
  logic [DW-1:0] resp_q[$];
  int            lat = 1;
  int            cd = 0;
  bit            pend = 0;
  bit            spur = 0;
  int            reads = 0;

  always @(negedge clk) begin
    rd_valid_i = 1'b0;
    if (rst) begin
      pend = 0;
    end else begin
      if (pend && cd == 0) begin
        rd_valid_i = 1'b1;
        rd_data_i = (resp_q.size() > 0) ? resp_q.pop_front() : '0;
        pend = 0;
      end else if (pend) begin
        cd--;
      end else if (spur) begin
        rd_valid_i = 1'b1;
        rd_data_i = 16'hFFFF;
      end
      if (rd_req_o) begin
        pend = 1;
        cd = lat - 1;
        reads++;
      end
    end
  end

  task automatic run(input logic [AW-1:0] a, input logic e, input int l,
                     input bit mid_start);
    lat = l;
    reads = 0;
    @(negedge clk);
    start_i = 1; addr_i = a; expect_i = e;
    @(negedge clk);
    start_i = 0;
    if (mid_start) begin
      @(negedge clk);
      start_i = 1; addr_i = ~a; expect_i = ~e;
      @(negedge clk);
      start_i = 0;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "busy", 32'(busy_o), 0);
    chk("R9", "done", 32'(done_o), 0);
    chk("R9", "pass/fail", 32'({pass_o, fail_o}), 0);
    chk("R9", "data", 32'(data_o), 0);
    chk("R9", "rd_req", 32'(rd_req_o), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R3 then R2: two clear-flag mismatches, match, extra read
    resp_q = '{16'h0080, 16'h0080, 16'h0012, 16'h1234};
    run(12'h123, 1'b0, 1, 0);
    chk("R3", "read count", 32'(reads), 4);
    chk("R2", "pass", 32'(pass_o), 1);
    chk("R2", "verified word", 32'(data_o), 32'h1234);

    // R4: erase, bit 5 set, recheck matches
    resp_q = '{16'h0000, 16'h0020, 16'h0080, 16'hFFFF};
    run(12'h400, 1'b1, 3, 0);
    chk("R4", "read count", 32'(reads), 4);
    chk("R4", "pass", 32'(pass_o), 1);

    // R5: recheck still mismatches
    resp_q = '{16'h0020, 16'h0020};
    run(12'h7FF, 1'b1, 2, 0);
    chk("R5", "read count", 32'(reads), 2);
    chk("R5", "fail", 32'(fail_o), 1);
    chk("R7", "pass cleared", 32'(pass_o), 0);

    // R6: poll budget exhausted
    resp_q = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
    run(12'h055, 1'b1, 1, 0);
    chk("R6", "read count", 32'(reads), MAXP);
    chk("R6", "fail", 32'(fail_o), 1);

    // R4: bit 5 on the last allowed poll wins over the budget
    resp_q = '{16'h0000, 16'h0000, 16'h0000, 16'h0020, 16'h0080, 16'h00A5};
    run(12'h0F0, 1'b1, 2, 0);
    chk("R4", "read count", 32'(reads), 6);
    chk("R4", "pass", 32'(pass_o), 1);
    chk("R4", "verified word", 32'(data_o), 32'h00A5);

    // R1: start while busy has no effect; first-read match
    resp_q = '{16'h0055, 16'hABCD};
    run(12'h321, 1'b0, 3, 1);
    chk("R1", "read count", 32'(reads), 2);
    chk("R1", "verified word", 32'(data_o), 32'hABCD);

    // R8: spurious valid strobes while idle are ignored
    reads = 0;
    spur = 1;
    repeat (5) @(negedge clk);
    spur = 0;
    repeat (2) @(negedge clk);
    chk("R8", "busy after stray valid", 32'(busy_o), 0);
    chk("R8", "data after stray valid", 32'(data_o), 32'hABCD);
    chk("R8", "reads after stray valid", 32'(reads), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule